// File: doc/BRIEF.md
# Four-Mode 8-Bit Barrel Shifter

This block moves an 8-bit word by a distance of 0 to 7 bit places in one of four ways. It can rotate the word right, shift it left with zeros coming in, shift it right with zeros coming in, or shift it right while copying the sign bit in. It has no clock and no registers, so the result follows the inputs combinationally. It suits an ALU or an address path that needs any of these shifts in a single cycle.

The datapath shifts in one direction only. It is a logarithmic right shifter built from a cascade of mux stages, one per bit of the distance, with weights 1, 2 and 4. A left shift reverses the bit order of the word before the cascade and reverses it again after it. Each stage has a small fill selector for the bit positions that open at the top. Depending on the mode, that selector supplies the bits pushed out at the bottom, zeros, or copies of the stage's MSB.

Top module: `mshift8_core`

## Requirements
- R1: With `mode` = 2'b00, `data_out` equals `data_in` rotated right by `amount`: bit i of the result is bit (i+amount) mod 8 of the input.
- R2: With `mode` = 2'b01, `data_out` equals `data_in` shifted left by `amount`, with zeros entering at bit 0.
- R3: With `mode` = 2'b10, `data_out` equals `data_in` shifted right by `amount`, with zeros entering at bit 7.
- R4: With `mode` = 2'b11, `data_out` equals `data_in` shifted right by `amount`, with copies of bit 7 entering at the top. For example, 8'h80 shifted by 7 gives 8'hFF.
- R5: With `amount` = 0, `data_out` equals `data_in` in every mode.
- R6: `data_out` depends only on the present inputs. It settles in the same time step as any input change, with no clock edge needed.
- R7: In rotate mode, `data_out` contains the same number of one bits as `data_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 8 | Word to be shifted |
| amount | input | 3 | Shift distance, 0 to 7 |
| mode | input | 2 | 00 rotate right, 01 logical left, 10 logical right, 11 arithmetic right |
| data_out | output | 8 | Shifted word |

## Verification
Whenever an input changes, the assertions check the following port relations:
- A zero distance leaves the word unchanged.
- A rotation keeps the count of one bits.
- A logical right shift by a nonzero distance clears the MSB.
- A left shift by a nonzero distance clears the LSB.
- An arithmetic shift keeps the sign bit.

These relations cannot pin down the exact bit placement for each distance. Only the bench's full sweep over every word, distance and mode shows that placement. The sweep compares each result with a value computed arithmetically, and it also shows that the output settles without any clock edge.

// File: rtl/mshift8_pkg.sv
package mshift8_pkg;
   typedef enum logic [1:0] {
      MODE_ROR = 2'b00,
      MODE_SLL = 2'b01,
      MODE_SRL = 2'b10,
      MODE_SRA = 2'b11
   } shift_mode_t;
endpackage

// File: rtl/mshift8_bitrev.sv
module mshift8_bitrev #(
   parameter int W = 8
) (
   input  logic         en,
   input  logic [W-1:0] word_i,
   output logic [W-1:0] word_o
);
   logic [W-1:0] flipped;

   for (genvar b = 0; b < W; b++) begin : g_flip
      assign flipped[b] = word_i[W-1-b];
   end

   assign word_o = en ? flipped : word_i;
endmodule

// File: rtl/mshift8_fillsel.sv
module mshift8_fillsel
   import mshift8_pkg::*;
(
   input  shift_mode_t mode,
   input  logic        wrap_bit,
   input  logic        sign_bit,
   output logic        fill_bit
);
   always_comb begin
      unique case (mode)
         MODE_ROR: fill_bit = wrap_bit;
         MODE_SRA: fill_bit = sign_bit;
         default:  fill_bit = 1'b0;
      endcase
   end
endmodule

// File: rtl/mshift8_stage.sv
module mshift8_stage
   import mshift8_pkg::*;
#(
   parameter int W  = 8,
   parameter int SH = 1
) (
   input  shift_mode_t  mode,
   input  logic         en,
   input  logic [W-1:0] word_i,
   output logic [W-1:0] word_o
);
   if (SH < 1 || SH >= W) begin : g_bad_sh
      $error("mshift8_stage: SH must lie in 1..W-1");
   end

   logic [SH-1:0] fill;

   for (genvar k = 0; k < SH; k++) begin : g_fill
      mshift8_fillsel u_fill (
         .mode     (mode),
         .wrap_bit (word_i[k]),
         .sign_bit (word_i[W-1]),
         .fill_bit (fill[k])
      );
   end

   assign word_o = en ? {fill, word_i[W-1:SH]} : word_i;
endmodule

// File: rtl/mshift8_core.sv
module mshift8_core
   import mshift8_pkg::*;
#(
   parameter  int W     = 8,
   localparam int AMT_W = $clog2(W)
) (
   input  logic [W-1:0]     data_in,
   input  logic [AMT_W-1:0] amount,
   input  logic [1:0]       mode,
   output logic [W-1:0]     data_out
);
   if (W < 2 || (1 << AMT_W) != W) begin : g_bad_w
      $error("mshift8_core: W must be a power of two, at least 2");
   end

   shift_mode_t mode_e;
   logic        flip_en;
   logic [W-1:0] chain [AMT_W+1];

   assign mode_e  = shift_mode_t'(mode);
   assign flip_en = ~mode[1] & mode[0];

   mshift8_bitrev #(.W(W)) u_rev_in (
      .en     (flip_en),
      .word_i (data_in),
      .word_o (chain[0])
   );

   for (genvar s = 0; s < AMT_W; s++) begin : g_stage
      mshift8_stage #(.W(W), .SH(1 << s)) u_stage (
         .mode   (mode_e),
         .en     (amount[s]),
         .word_i (chain[s]),
         .word_o (chain[s+1])
      );
   end

   mshift8_bitrev #(.W(W)) u_rev_out (
      .en     (flip_en),
      .word_i (chain[AMT_W]),
      .word_o (data_out)
   );
endmodule

// File: rtl/mshift8_chk.sv
module mshift8_chk #(
   parameter  int W     = 8,
   localparam int AMT_W = $clog2(W)
) (
   input logic [W-1:0]     data_in,
   input logic [AMT_W-1:0] amount,
   input logic [1:0]       mode,
   input logic [W-1:0]     data_out
);
   always_comb begin
      // R5
      zero_amount_identity_chk: assert (amount != '0 || data_out == data_in)
         else $error("zero distance changed the word");
      // R7
      rotate_popcount_chk: assert (mode != 2'b00 || $countones(data_out) == $countones(data_in))
         else $error("rotation changed the number of ones");
      // R3
      srl_top_clear_chk: assert (mode != 2'b10 || amount == '0 || !data_out[W-1])
         else $error("logical right shift left MSB set");
      // R2
      sll_bottom_clear_chk: assert (mode != 2'b01 || amount == '0 || !data_out[0])
         else $error("left shift left LSB set");
      // R4
      sra_sign_keep_chk: assert (mode != 2'b11 || data_out[W-1] == data_in[W-1])
         else $error("arithmetic shift lost the sign");
   end
endmodule

bind mshift8_core mshift8_chk #(.W(W)) u_chk (
   .data_in  (data_in),
   .amount   (amount),
   .mode     (mode),
   .data_out (data_out)
);

// File: tb/mshift8_core_bench.sv
module mshift8_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 100000;

   logic       clk = 1'b0;
   logic [7:0] data_in = '0;
   logic [2:0] amount = '0;
   logic [1:0] mode = '0;
   logic [7:0] data_out;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   mshift8_core u_mshift8_core (
      .data_in  (data_in),
      .amount   (amount),
      .mode     (mode),
      .data_out (data_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: mode=%0d amt=%0d in=%02h got %02h expected %02h",
                  req, mode, amount, data_in, act, exp);
      end
   endtask

   function automatic int expect_val(input int m, input int a, input int v);
      int s;
      case (m)
         0: return ((v >> a) | (v << (8 - a))) & 255;
         1: return (v << a) & 255;
         2: return v >> a;
         default: begin
            s = (v >= 128) ? v - 256 : v;
            return (s >>> a) & 255;
         end
      endcase
   endfunction

   function automatic int ones(input int v);
      int c = 0;
      for (int b = 0; b < 8; b++) c += (v >> b) & 1;
      return c;
   endfunction

   initial begin
      @(negedge clk);
      for (int m = 0; m < 4; m++) begin
         for (int a = 0; a < 8; a++) begin
            for (int v = 0; v < 256; v++) begin
               mode = m[1:0]; amount = a[2:0]; data_in = v[7:0];
               #1;
               case (m)
                  0: check("R1", data_out, expect_val(m, a, v));
                  1: check("R2", data_out, expect_val(m, a, v));
                  2: check("R3", data_out, expect_val(m, a, v));
                  default: check("R4", data_out, expect_val(m, a, v));
               endcase
               if (a == 0) check("R5", data_out, v);
               if (m == 0) check("R7", ones(data_out), ones(v));
            end
         end
      end
      // R4 corner: 0x80 by 7 gives 0xFF
      mode = 2'b11; amount = 3'd7; data_in = 8'h80; #1;
      check("R4", data_out, 8'hFF);
      // R6: changes with the clock held between edges, sampled right after
      @(posedge clk); #1;
      for (int v = 1; v < 256; v += 37) begin
         mode = 2'b00; amount = 3'd3; data_in = v[7:0]; #1;
         check("R6", data_out, expect_val(0, 3, v));
      end
      done = 1;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > MAX_CYCLES && !done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run hung, got %0d cycles expected < %0d", cycles, MAX_CYCLES);
         done = 1;
      end
   end

   initial begin
      wait (done);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule